// File: doc/BRIEF.md
# Serial Line Edge, Collision and Break Monitor

This block sits next to a serial transmitter and receiver and watches the receive line for three conditions: an active edge of selectable polarity, a bit error (the sampled receive level disagrees with the bit being sent, which shows a collision on a shared line), and a break reported by the receiver. Each condition sets a sticky flag. Software clears a flag by writing 1 to its bit. On the first bit error after a clear, the receive level that was seen is latched so software can tell which way the collision went.

The surrounding UART supplies a bit-sample strobe, the transmitted bit, a break indication and the two detection enables. Status and interrupt-enable registers are reached through a one-bit register select. Both registers can be read and written only while the alternate-map select is high. A single interrupt output ORs together every flag whose enable is set. The receive input passes through a synchronizer before any detection.

Top module: `uart_line_monitor`

## Requirements
- R1: The edge flag (status bit 7) sets on a falling edge of the synchronized receive line when `rxPolarity` is 0, and on a rising edge when it is 1. An edge of the other direction leaves it unchanged. The flag can be read 3 clock edges after the line changes.
- R2: A status flag is cleared only by a write with a 1 in that flag's bit (bit 7 edge, bit 1 bit error, bit 0 break). A 0 in the bit leaves the flag unchanged. If a set event and a clearing write happen in the same cycle, the flag stays set.
- R3: The bit-error flag (status bit 1) sets one cycle after `bitStrobe` is high, `berrDetEn` is high and the synchronized receive level differs from `txBit`. It does not set when detection is off or when the levels match.
- R4: Status bit 2 holds the receive level captured when the bit-error flag went from clear to set. 1 means high was seen where low was sent, and 0 means low was seen where high was sent. Later mismatches do not change it while the flag stays set.
- R5: The break flag (status bit 0) sets one cycle after `breakRcvd` is high while `brkDetEn` is high, and never while `brkDetEn` is low.
- R6: `irqOut` is high exactly when at least one flag is set together with its enable. The enable register holds the edge enable in bit 7, the bit-error enable in bit 1 and the break enable in bit 0.
- R7: Unused bits of both registers read 0. Status bit 2 reads 0 while the bit-error flag is clear. All flags and enables are 0 after reset.
- R8: While `altMapSel` is 0, reads return 0 and writes change neither register. `regSel` 0 selects status and 1 selects enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| altMapSel | input | 1 | Register window select; access only when 1 |
| regSel | input | 1 | 0 = status register, 1 = enable register |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data (combinational) |
| rxLine | input | 1 | Asynchronous receive line |
| rxPolarity | input | 1 | Active edge select: 0 falling, 1 rising |
| bitStrobe | input | 1 | One-cycle bit sample strobe |
| txBit | input | 1 | Bit currently being transmitted |
| berrDetEn | input | 1 | Bit-error detection enable |
| breakRcvd | input | 1 | Break received indication |
| brkDetEn | input | 1 | Break detection enable |
| irqOut | output | 1 | Combined interrupt request |

## Verification
A receive-line change reaches the edge flag on the third rising edge after it is driven: two synchronizer stages, then the flag register. The bit-error and break flags are due on the first edge after their strobe, and reads and the interrupt follow the flags combinationally. The bench drives inputs on falling edges. After a line change it waits four falling edges before it samples anything or applies a bit strobe, so the synchronized level is settled before it is compared. Strobe and break checks are sampled one falling edge after the pulse.

// File: rtl/uart_lem_pkg.sv
package uart_lem_pkg;
  localparam int REG_W    = 8;
  localparam int EDGE_BIT = 7;
  localparam int EVAL_BIT = 2;
  localparam int BERR_BIT = 1;
  localparam int BRK_BIT  = 0;

  typedef struct packed {
    logic clrEdge;
    logic clrBerr;
    logic clrBrk;
    logic loadEn;
    logic enEdgeVal;
    logic enBerrVal;
    logic enBrkVal;
  } lemStrobeT;
endpackage

// File: rtl/lem_sync.sv
module lem_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[0] <= RESET_VAL;
        else       chain[0] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[i] <= RESET_VAL;
        else       chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/lem_ctrl.sv
module lem_ctrl
  import uart_lem_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             altMapSel,
  input  logic             regSel,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic [REG_W-1:0] statusByte,
  input  logic [REG_W-1:0] enableByte,
  output lemStrobeT        strobes,
  output logic [REG_W-1:0] regRdData
);
  logic wrOk;
  logic unusedWrBits;

  assign wrOk = regWrEn && altMapSel;
  assign unusedWrBits = ^regWrData[6:2];

  always_comb begin
    strobes           = '0;
    strobes.clrEdge   = wrOk && !regSel && regWrData[EDGE_BIT];
    strobes.clrBerr   = wrOk && !regSel && regWrData[BERR_BIT];
    strobes.clrBrk    = wrOk && !regSel && regWrData[BRK_BIT];
    strobes.loadEn    = wrOk && regSel;
    strobes.enEdgeVal = regWrData[EDGE_BIT];
    strobes.enBerrVal = regWrData[BERR_BIT];
    strobes.enBrkVal  = regWrData[BRK_BIT];
  end

  always_comb begin
    if (!altMapSel)  regRdData = '0;
    else if (regSel) regRdData = enableByte;
    else             regRdData = statusByte;
  end

  p_read_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    !altMapSel |-> (regRdData == '0));
  p_write_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    !altMapSel |-> !(strobes.clrEdge || strobes.clrBerr || strobes.clrBrk || strobes.loadEn));
endmodule

// File: rtl/lem_datapath.sv
module lem_datapath
  import uart_lem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic             rxPolarity,
  input  logic             bitStrobe,
  input  logic             txBit,
  input  logic             berrDetEn,
  input  logic             breakRcvd,
  input  logic             brkDetEn,
  input  lemStrobeT        strobes,
  output logic [REG_W-1:0] statusByte,
  output logic [REG_W-1:0] enableByte,
  output logic             irqOut
);
  logic rxSync, rxPrev;
  logic edgeHit, berrHit, brkHit;
  logic edgeFlag, berrFlag, brkFlag, errVal;
  logic enEdge, enBerr, enBrk;

  lem_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_rxSync (
    .clk(clk), .rstN(rstN), .din(rxLine), .dout(rxSync)
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) rxPrev <= 1'b1;
    else       rxPrev <= rxSync;

  assign edgeHit = rxPolarity ? (rxSync && !rxPrev) : (!rxSync && rxPrev);
  assign berrHit = bitStrobe && berrDetEn && (rxSync != txBit);
  assign brkHit  = breakRcvd && brkDetEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeFlag <= 1'b0;
      berrFlag <= 1'b0;
      brkFlag  <= 1'b0;
      errVal   <= 1'b0;
    end else begin
      edgeFlag <= edgeHit || (edgeFlag && !strobes.clrEdge);
      berrFlag <= berrHit || (berrFlag && !strobes.clrBerr);
      brkFlag  <= brkHit  || (brkFlag  && !strobes.clrBrk);
      if (berrHit && !berrFlag) errVal <= rxSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enEdge <= 1'b0;
      enBerr <= 1'b0;
      enBrk  <= 1'b0;
    end else if (strobes.loadEn) begin
      enEdge <= strobes.enEdgeVal;
      enBerr <= strobes.enBerrVal;
      enBrk  <= strobes.enBrkVal;
    end
  end

  always_comb begin
    statusByte           = '0;
    statusByte[EDGE_BIT] = edgeFlag;
    statusByte[EVAL_BIT] = errVal && berrFlag;
    statusByte[BERR_BIT] = berrFlag;
    statusByte[BRK_BIT]  = brkFlag;
    enableByte           = '0;
    enableByte[EDGE_BIT] = enEdge;
    enableByte[BERR_BIT] = enBerr;
    enableByte[BRK_BIT]  = enBrk;
  end

  assign irqOut = (edgeFlag && enEdge) || (berrFlag && enBerr) || (brkFlag && enBrk);

  p_edge_cause_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(edgeFlag) |-> $past(rxSync != rxPrev));
  p_clear_by_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(berrFlag) |-> $past(strobes.clrBerr));
  p_berr_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(berrFlag) |-> $past(berrDetEn && bitStrobe));
  p_errval_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (berrFlag && $past(berrFlag)) |-> $stable(errVal));
  p_brk_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(brkFlag) |-> $past(brkDetEn && breakRcvd));
endmodule

// File: rtl/uart_line_monitor.sv
module uart_line_monitor
  import uart_lem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       altMapSel,
  input  logic       regSel,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       rxLine,
  input  logic       rxPolarity,
  input  logic       bitStrobe,
  input  logic       txBit,
  input  logic       berrDetEn,
  input  logic       breakRcvd,
  input  logic       brkDetEn,
  output logic       irqOut
);
  lemStrobeT        strobes;
  logic [REG_W-1:0] statusByte, enableByte;

  lem_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .altMapSel(altMapSel), .regSel(regSel),
    .regWrEn(regWrEn), .regWrData(regWrData), .statusByte(statusByte),
    .enableByte(enableByte), .strobes(strobes), .regRdData(regRdData)
  );

  lem_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .rxPolarity(rxPolarity),
    .bitStrobe(bitStrobe), .txBit(txBit), .berrDetEn(berrDetEn),
    .breakRcvd(breakRcvd), .brkDetEn(brkDetEn), .strobes(strobes),
    .statusByte(statusByte), .enableByte(enableByte), .irqOut(irqOut)
  );
endmodule

// File: tb/test_uart_line_monitor.sv
`timescale 1ns/1ps
module test_uart_line_monitor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic altMapSel = 1'b0, regSel = 1'b0, regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic rxLine = 1'b1, rxPolarity = 1'b0, bitStrobe = 1'b0, txBit = 1'b0;
  logic berrDetEn = 1'b0, breakRcvd = 1'b0, brkDetEn = 1'b0;
  logic irqOut;

  int testCnt = 0, failCnt = 0;
  logic eEdge = 0, eBerr = 0, eBrk = 0, eVal = 0;
  logic eEnE = 0, eEnB = 0, eEnK = 0;
  logic curRx = 1'b1;

  always #2.5 clk = ~clk;

  uart_line_monitor i_uart_line_monitor (
    .clk(clk), .rstN(rstN), .altMapSel(altMapSel), .regSel(regSel),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .rxLine(rxLine), .rxPolarity(rxPolarity), .bitStrobe(bitStrobe),
    .txBit(txBit), .berrDetEn(berrDetEn), .breakRcvd(breakRcvd),
    .brkDetEn(brkDetEn), .irqOut(irqOut)
  );

  function automatic logic [7:0] expStatus();
    return {eEdge, 4'b0000, eBerr & eVal, eBerr, eBrk};
  endfunction
  function automatic logic [7:0] expEnable();
    return {eEnE, 5'b00000, eEnB, eEnK};
  endfunction
  function automatic logic expIrq();
    return (eEdge & eEnE) | (eBerr & eEnB) | (eBrk & eEnK);
  endfunction

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic readReg(logic sel, output logic [7:0] val);
    altMapSel = 1'b1; regSel = sel; #0.5; val = regRdData;
  endtask

  task automatic checkAll(string tag);
    logic [7:0] v;
    readReg(1'b0, v); chk({tag, " R1/R3/R4/R5/R7 status"}, v, expStatus());
    readReg(1'b1, v); chk({tag, " R6/R7 enable"}, v, expEnable());
    chk({tag, " R6 irq"}, {7'd0, irqOut}, {7'd0, expIrq()});
  endtask

  task automatic wrReg(logic sel, logic [7:0] d, logic alt);
    regSel = sel; regWrData = d; altMapSel = alt; regWrEn = 1'b1;
    tick(); regWrEn = 1'b0; altMapSel = 1'b1;
    if (alt && !sel) begin
      if (d[7]) eEdge = 0;
      if (d[1]) eBerr = 0;
      if (d[0]) eBrk = 0;
    end else if (alt && sel) begin
      eEnE = d[7]; eEnB = d[1]; eEnK = d[0];
    end
  endtask

  task automatic opEdge(logic v, logic pol);
    rxPolarity = pol;
    if (curRx != v && ((pol == 1'b0 && v == 1'b0) || (pol == 1'b1 && v == 1'b1))) eEdge = 1;
    rxLine = v; curRx = v;
    tick(4);
  endtask

  task automatic opStrobe(logic tx, logic en);
    txBit = tx; berrDetEn = en; bitStrobe = 1'b1;
    tick(); bitStrobe = 1'b0;
    if (en && (curRx != tx)) begin
      if (!eBerr) eVal = curRx;
      eBerr = 1;
    end
  endtask

  task automatic opBreak(logic en, logic clrSame);
    breakRcvd = 1'b1; brkDetEn = en;
    if (clrSame) begin
      regSel = 1'b0; regWrData = 8'h01; altMapSel = 1'b1; regWrEn = 1'b1;
    end
    tick(); breakRcvd = 1'b0; regWrEn = 1'b0;
    if (en) eBrk = 1;
    else if (clrSame) eBrk = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [7:0] v;
    tick(3); rstN = 1'b1; tick(2);
    checkAll("reset");

    // R1 falling edge with polarity 0, then R2 write-0 no effect and write-1 clear
    opEdge(1'b0, 1'b0); checkAll("R1 fall pol0");
    wrReg(1'b0, 8'h00, 1'b1); checkAll("R2 write0 keeps");
    wrReg(1'b0, 8'h80, 1'b1); checkAll("R2 write1 clears");
    opEdge(1'b1, 1'b0); checkAll("R1 rise pol0 ignored");
    opEdge(1'b0, 1'b1); checkAll("R1 fall pol1 ignored");
    opEdge(1'b1, 1'b1); checkAll("R1 rise pol1");
    wrReg(1'b0, 8'h80, 1'b1);

    // R3 / R4
    opStrobe(1'b0, 1'b0); checkAll("R3 detect off");
    opStrobe(1'b1, 1'b1); checkAll("R3 match");
    opStrobe(1'b0, 1'b1); checkAll("R3 R4 high seen low sent");
    opEdge(1'b0, 1'b0); wrReg(1'b0, 8'h80, 1'b1);
    opStrobe(1'b1, 1'b1); checkAll("R4 no overwrite");
    wrReg(1'b0, 8'h02, 1'b1); checkAll("R7 errval hidden");
    opStrobe(1'b1, 1'b1); checkAll("R4 low seen high sent");

    // R5 and set-wins
    opBreak(1'b0, 1'b0); checkAll("R5 break off");
    opBreak(1'b1, 1'b0); checkAll("R5 break on");
    opBreak(1'b1, 1'b1); checkAll("R2 set wins");

    // R6
    wrReg(1'b1, 8'h01, 1'b1); checkAll("R6 brk enable");
    wrReg(1'b1, 8'hFF, 1'b1); checkAll("R6 R7 all enables");

    // R8
    wrReg(1'b1, 8'h00, 1'b0); checkAll("R8 enable write ignored");
    wrReg(1'b0, 8'hFF, 1'b0); checkAll("R8 status write ignored");
    altMapSel = 1'b0; regSel = 1'b0; #0.5;
    chk("R8 status read gated", regRdData, 8'h00);
    regSel = 1'b1; #0.5;
    chk("R8 enable read gated", regRdData, 8'h00);
    altMapSel = 1'b1;

    // constrained random
    void'($urandom(32'd20240611));
    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(0, 5))
        0: opEdge(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        1: opStrobe(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        2: opBreak(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
        3: wrReg(1'b0, 8'($urandom), 1'($urandom_range(0, 3) != 0));
        4: wrReg(1'b1, 8'($urandom), 1'($urandom_range(0, 3) != 0));
        default: begin
          altMapSel = 1'b0; regSel = 1'($urandom_range(0, 1)); #0.5;
          chk("R8 random read gated", regRdData, 8'h00);
          altMapSel = 1'b1; tick();
        end
      endcase
      checkAll("random");
    end
    readReg(1'b0, v);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule